// File: doc/BRIEF.md
# Vectored Priority Interrupt Resolver

This block takes a vector of pending interrupt sources and decides whether the processor's normal interrupt line should be raised. Software assigns sources to sixteen numbered vector slots, each with its own service address. Slot 0 has the highest priority. Sources that are not assigned to any slot are served through a single default address. The block tracks which priority level is currently being serviced. While a level is in service, only sources of strictly higher priority can raise the interrupt line again, so a more urgent slot can interrupt a less urgent handler.

Software acknowledges an interrupt by reading the acknowledge register. The read returns the service address of the most urgent pending level and makes that level current. The previous level is saved on a small per-level stack. A write to the same register ends the service and restores the saved level. The enable mask and the fast-interrupt routing mask are inputs from a neighbouring block. The slot registers are programmed through a single-cycle, word-addressed register port.

Top module: `vec_irq_resolver`

## Requirements
- R1: After reset, all slot addresses, slot controls and the default address read as zero, and the current level is idle (17). At idle, any source that is pending, enabled and not fast-routed raises `irq`.
- R2: Register map, using byte offsets. Slot k address is at 0x100+4k. Slot k control is at 0x200+4k and holds 8 bits, zero-extended on read. The default address is at 0x34. The acknowledge register is at 0x30. Any other offset reads 0. `reg_rdata` is loaded at the clock edge that samples `reg_rd` and holds its value otherwise.
- R3: Control bit 5 enables a slot, and bits 4:0 name its source. `irq` is high exactly when some source that is pending, enabled and not fast-routed belongs to an enabled slot with index below the current level. At level 16 the default set is all enabled slots. At idle every source counts.
- R4: A source that is disabled in `src_enable`, or selected in `fast_select`, never raises `irq`.
- R5: An acknowledge read searches levels from 0 upward for the first level L whose set of higher slots (all slots below L+1) meets `src_raw`. If L is below the current level, the read saves the current level for L, makes L current, and returns the address of L. Level 16 returns the default address.
- R6: If an acknowledge read finds no level below the current one, the level is unchanged. The read returns the current level's address, or the default address at levels 16 and 17. At idle with nothing pending, it returns the default address.
- R7: While a level is in service, a pending source of lower priority does not raise `irq`, and a source of higher priority does.
- R8: A write to the acknowledge register ignores its data and restores the level saved for the current level. At idle it has no effect.
- R9: A change to a slot control affects `irq` from the clock edge that performs the write.
- R10: A pending source that belongs to no slot is acknowledged at level 16 with the default address. After that, only enabled slot sources raise `irq` until the service ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_raw | input | 32 | Pending sources (hardware OR software) |
| src_enable | input | 32 | Per-source enable mask |
| fast_select | input | 32 | Sources routed to the fast interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Normal interrupt request |

## Verification
The resolution logic is driven with four kinds of input. A single vectored source shows the slot address and the priority push. A pending lower slot together with a later higher slot shows that masking depends on the current level, not on the source alone. An unassigned source exercises level 16, which must hide itself but still let slot sources through. Fast-routed or disabled sources must stay invisible even at idle. Pop writes at idle, acknowledge reads with nothing pending, and a slot enable toggled while in service separate the stack restore, the empty search and the mask rebuild from one another.

// File: rtl/vir_pkg.sv
// Package: shared sizes and register offsets for the vectored interrupt
// resolver. Assumes source numbers fit in the control byte source field.
package vir_pkg;
    localparam int NUM_SRC   = 32;
    localparam int NUM_SLOT  = 16;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int CTRL_W    = 8;
    localparam int EN_BIT    = 5;
    localparam int SRC_W     = $clog2(NUM_SRC);
    localparam int NUM_LVL   = NUM_SLOT + 1;
    localparam int IDLE_LVL  = NUM_LVL;
    localparam int LVL_W     = $clog2(NUM_LVL + 1);
    localparam logic [ADDR_W-1:0] SLOT_ADDR_BASE = 12'h100;
    localparam logic [ADDR_W-1:0] SLOT_CTRL_BASE = 12'h200;
    localparam logic [ADDR_W-1:0] ACK_OFS        = 12'h030;
    localparam logic [ADDR_W-1:0] DEF_OFS        = 12'h034;
endpackage

// File: rtl/vir_slot_regs.sv
// Slot register file. Holds the per-slot service addresses (entry NUM_SLOT
// is the default address) and the per-slot control bytes. It assumes at most
// one write per cycle. All entries clear on reset.
module vir_slot_regs
    import vir_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] slot_addr [NUM_LVL],
    output logic [CTRL_W-1:0] slot_ctrl [NUM_SLOT]
);
    // Store addresses and controls on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_LVL; k++)  slot_addr[k] <= '0;
            for (int k = 0; k < NUM_SLOT; k++) slot_ctrl[k] <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < NUM_SLOT; k++) begin
                if (addr == SLOT_ADDR_BASE + ADDR_W'(4 * k)) slot_addr[k] <= wdata;
                if (addr == SLOT_CTRL_BASE + ADDR_W'(4 * k)) slot_ctrl[k] <= wdata[CTRL_W-1:0];
            end
            if (addr == DEF_OFS) slot_addr[NUM_SLOT] <= wdata;
        end
    end

    // R2
    ctrl_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SLOT_CTRL_BASE) |=> slot_ctrl[0] == $past(wdata[CTRL_W-1:0]));
endmodule

// File: rtl/vir_prio_masks.sv
// Priority mask builder. For each level p, mask p holds the sources of the
// enabled slots below p. The idle level uses an all-ones mask. The masks are
// purely combinational from the slot controls.
module vir_prio_masks
    import vir_pkg::*;
(
    input  logic [CTRL_W-1:0]  slot_ctrl [NUM_SLOT],
    output logic [NUM_SRC-1:0] masks     [NUM_LVL+1]
);
    assign masks[0]        = '0;
    assign masks[IDLE_LVL] = '1;

    // Each level adds its own slot's source to the mask of the level above.
    for (genvar p = 0; p < NUM_SLOT; p++) begin : g_lvl
        logic [NUM_SRC-1:0] own_bit;
        assign own_bit    = slot_ctrl[p][EN_BIT]
                          ? (NUM_SRC'(1) << slot_ctrl[p][SRC_W-1:0]) : '0;
        assign masks[p+1] = masks[p] | own_bit;
    end
endmodule

// File: rtl/vir_prio_stack.sv
// Priority tracker. Holds the current service level and one saved level per
// level. An acknowledge read pushes to the most urgent pending level. An
// acknowledge write pops. If both strobes arrive in one cycle, the pop wins.
module vir_prio_stack
    import vir_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pending,
    input  logic [NUM_SRC-1:0] masks [NUM_LVL+1],
    input  logic               ack_rd,
    input  logic               ack_wr,
    output logic [LVL_W-1:0]   cur_lvl,
    output logic [LVL_W-1:0]   ret_lvl
);
    logic [LVL_W-1:0] saved [NUM_LVL];
    logic             found;

    // Search upward for the first level that a pending source reaches.
    always_comb begin
        found   = 1'b0;
        ret_lvl = cur_lvl;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (!found && LVL_W'(i) < cur_lvl && |(pending & masks[i+1])) begin
                found   = 1'b1;
                ret_lvl = LVL_W'(i);
            end
        end
    end

    // Push on a productive acknowledge read; pop on an acknowledge write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_lvl <= LVL_W'(IDLE_LVL);
            for (int k = 0; k < NUM_LVL; k++) saved[k] <= LVL_W'(IDLE_LVL);
        end else if (ack_wr) begin
            if (cur_lvl < LVL_W'(IDLE_LVL)) cur_lvl <= saved[cur_lvl];
        end else if (ack_rd && found) begin
            saved[ret_lvl] <= cur_lvl;
            cur_lvl        <= ret_lvl;
        end
    end

    // R3
    lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_lvl <= LVL_W'(IDLE_LVL));
    // R5
    push_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !ack_wr && found) |=> cur_lvl < $past(cur_lvl));
    // R6
    empty_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !ack_wr && !found) |=> $stable(cur_lvl));
    // R8
    idle_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && cur_lvl == LVL_W'(IDLE_LVL)) |=> cur_lvl == LVL_W'(IDLE_LVL));
endmodule

// File: rtl/vec_irq_resolver.sv
// Vectored priority interrupt resolver, top level. It joins the slot
// registers, the mask builder and the priority tracker. It drives the
// interrupt line and serves register reads with one cycle of latency.
// It assumes the caller does not issue reg_rd and reg_wr in the same cycle.
module vec_irq_resolver
    import vir_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_raw,
    input  logic [NUM_SRC-1:0] src_enable,
    input  logic [NUM_SRC-1:0] fast_select,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq
);
    logic [DATA_W-1:0]  slot_addr [NUM_LVL];
    logic [CTRL_W-1:0]  slot_ctrl [NUM_SLOT];
    logic [NUM_SRC-1:0] masks     [NUM_LVL+1];
    logic [LVL_W-1:0]   cur_lvl, ret_lvl;
    logic [DATA_W-1:0]  rd_val;
    logic               ack_rd, ack_wr;

    assign ack_rd = reg_rd && reg_addr == ACK_OFS;
    assign ack_wr = reg_wr && reg_addr == ACK_OFS;

    vir_slot_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .slot_addr(slot_addr), .slot_ctrl(slot_ctrl)
    );

    vir_prio_masks u_masks (.slot_ctrl(slot_ctrl), .masks(masks));

    vir_prio_stack u_stack (
        .clk(clk), .rst_n(rst_n), .pending(src_raw), .masks(masks),
        .ack_rd(ack_rd), .ack_wr(ack_wr), .cur_lvl(cur_lvl), .ret_lvl(ret_lvl)
    );

    // Raise the line for eligible sources above the current level.
    assign irq = |(src_raw & src_enable & ~fast_select & masks[cur_lvl]);

    // Select read data by offset.
    always_comb begin
        rd_val = '0;
        for (int k = 0; k < NUM_SLOT; k++) begin
            if (reg_addr == SLOT_ADDR_BASE + ADDR_W'(4 * k)) rd_val = slot_addr[k];
            if (reg_addr == SLOT_CTRL_BASE + ADDR_W'(4 * k)) rd_val = DATA_W'(slot_ctrl[k]);
        end
        if (reg_addr == DEF_OFS) rd_val = slot_addr[NUM_SLOT];
        if (reg_addr == ACK_OFS)
            rd_val = (ret_lvl >= LVL_W'(NUM_SLOT)) ? slot_addr[NUM_SLOT] : slot_addr[ret_lvl];
    end

    // Register read data on the read strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_val;
    end

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
    // R4
    irq_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> |(src_raw & src_enable & ~fast_select));
endmodule

// File: tb/vec_irq_resolver_bench.sv
module vec_irq_resolver_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_raw = '0, src_enable = '0, fast_select = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq;
    int          checks = 0, errors = 0;

    localparam logic [11:0] ACK = 12'h030, DEF = 12'h034;

    always #5 clk = ~clk;

    vec_irq_resolver u_vec_irq_resolver (
        .clk(clk), .rst_n(rst_n), .src_raw(src_raw), .src_enable(src_enable),
        .fast_select(fast_select), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk); src_raw = v;
        #1;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 irq idle nothing pending", 32'(irq), 0);
        rd(12'h100, d); chk("R1 slot0 addr zero", d, 0);
        rd(12'h200, d); chk("R1 slot0 ctrl zero", d, 0);
        rd(DEF, d);     chk("R1 default zero", d, 0);
        src_enable = '1;
        set_src(32'h200); chk("R1 idle passes unassigned source", 32'(irq), 1);
        set_src(0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        wr(12'h100, 32'h100); wr(12'h200, 32'h22);   // slot0: source 2
        wr(12'h10C, 32'hA3);  wr(12'h20C, 32'h25);   // slot3: source 5
        wr(12'h11C, 32'h700); wr(12'h21C, 32'h2C);   // slot7: source 12
        wr(DEF, 32'hDEF);
        wr(12'h224, 32'h1D3);                        // slot9 disabled, 8 bits kept
        rd(12'h10C, d); chk("R2 slot3 addr readback", d, 32'hA3);
        rd(12'h20C, d); chk("R2 slot3 ctrl readback", d, 32'h25);
        rd(12'h224, d); chk("R2 ctrl truncated to 8 bits", d, 32'hD3);
        rd(DEF, d);     chk("R2 default readback", d, 32'hDEF);
        rd(12'h008, d); chk("R2 unmapped reads zero", d, 0);
        repeat (2) @(negedge clk);
        chk("R2 rdata holds without strobe", reg_rdata, 0);
    endtask

    task automatic t_gating;
        set_src(32'h200);   chk("R3 idle unassigned pending", 32'(irq), 1);
        fast_select = 32'h200; #1; chk("R4 fast-routed hidden", 32'(irq), 0);
        fast_select = 0; src_enable = ~32'h200; #1; chk("R4 disabled hidden", 32'(irq), 0);
        src_enable = '1;
        set_src(0);
    endtask

    task automatic t_nesting;
        logic [31:0] d;
        set_src(32'h20); chk("R3 slot3 source raises", 32'(irq), 1);
        rd(ACK, d);      chk("R5 ack returns slot3 addr", d, 32'hA3);
        chk("R3 in service hides own source", 32'(irq), 0);
        set_src(32'h1020); chk("R7 lower slot7 masked", 32'(irq), 0);
        set_src(32'h1024); chk("R7 higher slot0 preempts", 32'(irq), 1);
        rd(ACK, d);      chk("R5 nested ack slot0 addr", d, 32'h100);
        chk("R3 level0 masks all", 32'(irq), 0);
        wr(ACK, 32'hFFFF); chk("R8 pop back to slot3 level", 32'(irq), 1);
        set_src(32'h1020); chk("R8 slot3 level still masks", 32'(irq), 0);
        wr(ACK, 0);      chk("R8 pop to idle", 32'(irq), 1);
        rd(ACK, d);      chk("R5 search picks slot3 over slot7", d, 32'hA3);
        wr(ACK, 0);
        set_src(0);
    endtask

    task automatic t_default;
        logic [31:0] d;
        set_src(32'h200);
        rd(ACK, d);      chk("R10 unassigned gets default addr", d, 32'hDEF);
        chk("R10 default level hides unassigned", 32'(irq), 0);
        set_src(32'h220); chk("R10 slot source passes at default level", 32'(irq), 1);
        rd(ACK, d);      chk("R5 ack from default level", d, 32'hA3);
        wr(ACK, 0); wr(ACK, 0);
        chk("R8 two pops reach idle", 32'(irq), 1);
        set_src(0);
    endtask

    task automatic t_idle;
        logic [31:0] d;
        wr(ACK, 0);
        rd(ACK, d);      chk("R6 empty ack returns default", d, 32'hDEF);
        set_src(32'h200); chk("R6 R8 still idle", 32'(irq), 1);
        set_src(0);
    endtask

    task automatic t_slot_write;
        logic [31:0] d;
        set_src(32'h200);
        rd(ACK, d);      chk("R10 enter default level", d, 32'hDEF);
        chk("R9 before slot write", 32'(irq), 0);
        wr(12'h204, 32'h29); chk("R9 slot1 enable takes effect", 32'(irq), 1);
        wr(12'h204, 32'h09); chk("R3 enable bit cleared hides", 32'(irq), 0);
        wr(ACK, 0);      chk("R8 pop from default to idle", 32'(irq), 1);
        set_src(0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_regs();
        t_gating();
        t_nesting();
        t_default();
        t_idle();
        t_slot_write();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule